// File: doc/BRIEF.md
# Packet Length and Checksum Checker

This block sits on one 16-bit receive channel and checks framed packets as they stream in. A packet opens with a command word, flagged by a start-of-packet marker. Sixteen data words follow, and a check word closes the packet. The block takes the destination port from the command word and counts the words that arrive. It keeps a running XOR of the data words and compares that value with the check word. When the packet ends, it gives a single verdict.

Data words leave the block one cycle after they arrive, tagged with the port chosen by their command word. A downstream switch can then steer them to one of four outputs. The command word and the check word stay inside the block. A packet that is cut short by a new start-of-packet is closed with a length error. A word that arrives outside any packet is dropped and reported as a framing error.

Top module: `pkt_frame_checker`

## Requirements
- R1: After synchronous reset, `out_valid`, `stat_valid`, the three result flags and `frame_err` are all low, and the block is idle. A word without start-of-packet that arrives straight after reset raises `frame_err`.
- R2: A word with `in_valid` and `in_sop` both high is a command word. Its bits [1:0] give the destination port (0 to 3), and it is never forwarded: `out_valid` stays low in the cycle that follows it.
- R3: Each of the 16 data words after a command word appears on `out_word` one cycle after it is accepted. It comes with `out_valid` high and `out_port` equal to the port of its command word. At most 16 words are forwarded per packet.
- R4: The word after the 16th data word is the check word, and it is not forwarded. If it equals the XOR of the 16 data words, the next cycle shows `stat_valid` and `stat_pass` high, with both error flags low.
- R5: If the check word differs from the XOR of the data words in any bit, the next cycle shows `stat_valid` and `stat_crc_err` high, with `stat_pass` and `stat_len_err` low.
- R6: If a command word arrives while a packet is still in progress, whatever the number of data words received, the next cycle shows `stat_valid` and `stat_len_err` high, with `stat_pass` and `stat_crc_err` low. The new packet starts at once, with a fresh XOR, a fresh count and its own port.
- R7: A word that arrives without start-of-packet while the block is idle is not forwarded, and `frame_err` is high for exactly the next cycle. This includes any word that follows a check word.
- R8: Cycles with `in_valid` low change nothing. They are not counted, not forwarded and not folded into the XOR, and they raise no strobe in the following cycle.
- R9: Whenever `stat_valid` is high, exactly one of `stat_pass`, `stat_len_err` and `stat_crc_err` is high. When `stat_valid` is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word strobe |
| in_sop | input | 1 | Marks the input word as a command word |
| in_word | input | 16 | Input word |
| out_valid | output | 1 | Forwarded data word is valid |
| out_word | output | 16 | Forwarded data word |
| out_port | output | 2 | Destination port of the forwarded word |
| stat_valid | output | 1 | One-cycle packet verdict strobe |
| stat_pass | output | 1 | Packet length and checksum correct |
| stat_len_err | output | 1 | Packet cut short by a new command word |
| stat_crc_err | output | 1 | Check word does not match the XOR |
| frame_err | output | 1 | Word received outside any packet |

## Verification
Two events can share one clock edge. When a command word arrives mid-packet, the verdict on the old packet and the capture of the new packet's port happen on that same edge. The bench cuts packets short after every data count from 0 to 16, always with a different port, and sends a new command word at that point. It then expects a length-error verdict in the next cycle, followed by the new port on the next forwarded word. A check word with a single flipped bit, swept over all 16 bit positions and all four ports, tests the checksum comparison. The bench sends that check word in the cycle after the last data word, so that the verdict arrives straight after the last forwarded output.

// File: rtl/pkt_frame_checker.sv
module pkt_frame_checker #(
  parameter int WORD_W     = 16,
  parameter int DATA_WORDS = 16,
  parameter int NUM_PORTS  = 4,
  localparam int PORT_W    = $clog2(NUM_PORTS),
  localparam int CNT_W     = $clog2(DATA_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic [PORT_W-1:0] out_port,
  output logic              stat_valid,
  output logic              stat_pass,
  output logic              stat_len_err,
  output logic              stat_crc_err,
  output logic              frame_err
);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc;
  logic [PORT_W-1:0] port;

  wire is_cmd   = in_valid &&  in_sop;
  wire is_body  = in_valid && !in_sop &&  busy;
  wire is_stray = in_valid && !in_sop && !busy;
  wire at_check = (cnt == CNT_W'(DATA_WORDS));
  wire is_data  = is_body && !at_check;
  wire is_check = is_body &&  at_check;
  wire sum_ok   = (in_word == acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      port <= '0;
    end else if (is_cmd) begin
      busy <= 1'b1;
      cnt  <= '0;
      acc  <= '0;
      port <= in_word[PORT_W-1:0];
    end else if (is_data) begin
      cnt <= cnt + CNT_W'(1);
      acc <= acc ^ in_word;
    end else if (is_check) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_word     <= '0;
      out_port     <= '0;
      stat_valid   <= 1'b0;
      stat_pass    <= 1'b0;
      stat_len_err <= 1'b0;
      stat_crc_err <= 1'b0;
      frame_err    <= 1'b0;
    end else begin
      out_valid    <= is_data;
      if (is_data) begin
        out_word <= in_word;
        out_port <= port;
      end
      stat_valid   <= is_check || (is_cmd && busy);
      stat_pass    <= is_check && sum_ok;
      stat_crc_err <= is_check && !sum_ok;
      stat_len_err <= is_cmd && busy;
      frame_err    <= is_stray;
    end
  end

endmodule

// File: rtl/pkt_frame_checker_props.sv
module pkt_frame_checker_props #(
  parameter int WORD_W     = 16,
  parameter int DATA_WORDS = 16,
  parameter int PORT_W     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_sop,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_word,
  input logic [PORT_W-1:0] out_port,
  input logic              stat_valid,
  input logic              stat_pass,
  input logic              stat_len_err,
  input logic              stat_crc_err,
  input logic              frame_err
);

  localparam int FC_W = $clog2(DATA_WORDS + 2);
  logic [FC_W-1:0] fwd_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  fwd_cnt <= '0;
    else if (in_valid && in_sop) fwd_cnt <= '0;
    else if (out_valid)       fwd_cnt <= fwd_cnt + FC_W'(1);
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !stat_valid && !frame_err));

  p_cmd_not_fwd_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sop) |=> !out_valid);

  p_fwd_word_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid && !in_sop) && out_word == $past(in_word)));

  p_fwd_bound_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (fwd_cnt < FC_W'(DATA_WORDS)));

  p_stat_source_r4: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> ($past(in_valid) && !out_valid));

  p_len_on_sop_r6: assert property (@(posedge clk) disable iff (rst)
    stat_len_err |-> $past(in_valid && in_sop));

  p_frame_excl_r7: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (!out_valid && !stat_valid && $past(in_valid && !in_sop)));

  p_gap_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !stat_valid && !frame_err));

  p_one_result_r9: assert property (@(posedge clk) disable iff (rst)
    stat_valid |-> ($countones({stat_pass, stat_len_err, stat_crc_err}) == 1));

  p_flags_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !stat_valid |-> (!stat_pass && !stat_len_err && !stat_crc_err));

endmodule

bind pkt_frame_checker pkt_frame_checker_props #(
  .WORD_W(WORD_W), .DATA_WORDS(DATA_WORDS), .PORT_W(PORT_W)
) u_props (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_word(in_word),
  .out_valid(out_valid), .out_word(out_word), .out_port(out_port),
  .stat_valid(stat_valid), .stat_pass(stat_pass), .stat_len_err(stat_len_err),
  .stat_crc_err(stat_crc_err), .frame_err(frame_err)
);

// File: tb/sim_pkt_frame_checker.sv
module sim_pkt_frame_checker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_sop = 1'b0;
  logic [15:0] in_word = '0;
  logic out_valid, stat_valid, stat_pass, stat_len_err, stat_crc_err, frame_err;
  logic [15:0] out_word;
  logic [1:0] out_port;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pkt_frame_checker u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sop(in_sop), .in_word(in_word),
    .out_valid(out_valid), .out_word(out_word), .out_port(out_port),
    .stat_valid(stat_valid), .stat_pass(stat_pass), .stat_len_err(stat_len_err),
    .stat_crc_err(stat_crc_err), .frame_err(frame_err)
  );

  function automatic logic [15:0] dword(input int p, input int i);
    return 16'h3c5a ^ 16'(i * 16'h1021) ^ 16'(p << 12) ^ 16'(i << 3);
  endfunction

  task automatic step(input logic v, input logic s, input logic [15:0] w,
                      input logic eov, input logic [15:0] ew, input logic [1:0] ep,
                      input logic esv, input logic epa, input logic ele, input logic ecr,
                      input logic efe, input string tag);
    logic ok;
    @(negedge clk);
    in_valid = v; in_sop = s; in_word = w;
    @(posedge clk); #1;
    checks++;
    ok = (out_valid == eov) && (stat_valid == esv) && (stat_pass == epa) &&
         (stat_len_err == ele) && (stat_crc_err == ecr) && (frame_err == efe) &&
         (!eov || (out_word == ew && out_port == ep));
    if (!ok) begin
      errors++;
      $display("FAIL %s: got ov=%0b w=%h p=%0d sv=%0b pa=%0b le=%0b ce=%0b fe=%0b, exp ov=%0b w=%h p=%0d sv=%0b pa=%0b le=%0b ce=%0b fe=%0b",
               tag, out_valid, out_word, out_port, stat_valid, stat_pass, stat_len_err,
               stat_crc_err, frame_err, eov, ew, ep, esv, epa, ele, ecr, efe);
    end
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 16'hdead, 0, '0, '0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    checks++;
    if (out_valid || stat_valid || stat_pass || stat_len_err || stat_crc_err || frame_err) begin
      errors++;
      $display("FAIL R1: outputs after reset ov=%0b sv=%0b fe=%0b, exp all 0",
               out_valid, stat_valid, frame_err);
    end
  endtask

  // Sends a command and ndata data words; optional check word xor'd with cmask.
  task automatic packet(input int p, input int ndata, input logic send_chk,
                        input logic [15:0] cmask, input logic gaps, input logic aborting);
    logic [15:0] acc = '0;
    step(1'b1, 1'b1, 16'(16'ha5a0 | p), 0, '0, '0, aborting, 0, aborting, 0, 0,
         aborting ? "R6 abort" : "R2 command");
    for (int i = 0; i < ndata; i++) begin
      logic [15:0] w = dword(p, i);
      if (gaps && i[0]) idle("R8 gap");
      acc ^= w;
      step(1'b1, 1'b0, w, 1, w, 2'(p), 0, 0, 0, 0, 0, "R3 data");
    end
    if (send_chk)
      step(1'b1, 1'b0, acc ^ cmask, 0, '0, '0, 1, cmask == 0, 0, cmask != 0, 0,
           cmask == 0 ? "R4 pass" : "R5 crc");
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: run did not complete, exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    step(1'b1, 1'b0, 16'h1234, 0, '0, '0, 0, 0, 0, 0, 1, "R1 stray after reset");

    // R4/R5: every port, every single-bit corruption plus a clean check word
    for (int p = 0; p < 4; p++)
      for (int b = 0; b <= 16; b++) begin
        packet(p, 16, 1'b1, b == 16 ? 16'h0 : 16'(1 << b), 1'(b & 1), 1'b0);
        if (p == 3) step(1'b1, 1'b0, 16'hbeef, 0, '0, '0, 0, 0, 0, 0, 1, "R7 extra word");
      end

    // R6: packets cut short after every data count, new packet with another port
    for (int k = 0; k <= 16; k++) begin
      packet(k % 4, k, 1'b0, '0, 1'b0, 1'b0);
      packet((k + 1) % 4, 16, 1'b1, '0, 1'b0, 1'b1);
    end

    // R7: stray words while idle, between gaps
    step(1'b1, 1'b0, 16'h0001, 0, '0, '0, 0, 0, 0, 0, 1, "R7 stray");
    idle("R7 quiet after stray");
    step(1'b1, 1'b0, 16'h0002, 0, '0, '0, 0, 0, 0, 0, 1, "R7 stray");

    // R1: reset mid-packet returns to idle
    packet(2, 5, 1'b0, '0, 1'b0, 1'b0);
    do_reset();
    step(1'b1, 1'b0, 16'h4321, 0, '0, '0, 0, 0, 0, 0, 1, "R1 idle after mid reset");
    packet(1, 16, 1'b1, '0, 1'b1, 1'b0);
    idle("R9 flags low");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule